// File: doc/BRIEF.md
# Circuit-Switched Streaming Switch Node

This block is one node in a linear chain of switch nodes that moves 32-bit word streams between hardware modules. Each node serves one attached module through a producer queue (words the module sends) and a consumer queue (words the module receives). It also has a pool of rightbound lanes and a separate pool of leftbound lanes toward its two neighbours. Every hop uses valid/ready flow control, and each lane carries a last flag beside the data word.

A stream opens with a header word whose low `ADDR_W` bits name the destination node. When a stream's input is idle and its header is present, the node compares the destination with its own index and reserves an output. The output is either the local consumer, a rightbound lane or a leftbound lane. All later words then follow that reservation unchanged. The word that carries the last flag is passed on, and the reservation is released as it is accepted. Headers travel with the stream over every hop and are removed only at the node whose index matches.

Top module: `stream_switch_node`

## Requirements
- R1: After a synchronous active-low reset, no output is valid and no input is ready until a header has been routed.
- R2: A header whose destination field (bits `ADDR_W-1:0`) equals `NODE_ID` sends its stream to the consumer queue. The header itself is dropped and the remaining words, last flag included, arrive in order.
- R3: A header whose destination is greater than `NODE_ID` reserves a rightbound outgoing lane. The header is forwarded as the first word on that lane, followed by the rest of the stream.
- R4: A header whose destination is less than `NODE_ID` reserves a leftbound outgoing lane, with the header forwarded first.
- R5: The word carrying the last flag is delivered on the reserved output. The output is idle (valid low) in the following cycle and can then be reserved by another stream.
- R6: A new stream takes the lowest-numbered free lane of its pool, and no output is ever reserved by two streams at once.
- R7: When the needed output is busy, the header waits with its input's ready low. No word is lost, and the stream proceeds once the output is released.
- R8: Headers that want the same output in the same cycle are served in fixed order: rightbound inputs first (lane 0 ahead of lane 1), then leftbound inputs, and the local producer last.
- R9: With a lane free, a presented header appears on its outgoing lane one cycle later, well inside the ten-cycle setup bound.
- R10: A word moves only when the receiver is ready. While an output is valid and not ready, its data and valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prod_data | input | DATA_W | Word from the local module's producer queue |
| prod_last | input | 1 | Last-word flag of the producer stream |
| prod_valid | input | 1 | Producer word present |
| prod_ready | output | 1 | Producer word accepted |
| cons_data | output | DATA_W | Word to the local module's consumer queue |
| cons_last | output | 1 | Last-word flag toward the consumer |
| cons_valid | output | 1 | Consumer word present |
| cons_ready | input | 1 | Consumer queue can accept |
| rin_data | input | LANES_R*DATA_W | Rightbound lanes arriving from the left neighbour |
| rin_last | input | LANES_R | Last flags of arriving rightbound lanes |
| rin_valid | input | LANES_R | Valid of arriving rightbound lanes |
| rin_ready | output | LANES_R | Ready back to the left neighbour |
| rout_data | output | LANES_R*DATA_W | Rightbound lanes leaving to the right neighbour |
| rout_last | output | LANES_R | Last flags of leaving rightbound lanes |
| rout_valid | output | LANES_R | Valid of leaving rightbound lanes |
| rout_ready | input | LANES_R | Ready from the right neighbour |
| lin_data | input | LANES_L*DATA_W | Leftbound lanes arriving from the right neighbour |
| lin_last | input | LANES_L | Last flags of arriving leftbound lanes |
| lin_valid | input | LANES_L | Valid of arriving leftbound lanes |
| lin_ready | output | LANES_L | Ready back to the right neighbour |
| lout_data | output | LANES_L*DATA_W | Leftbound lanes leaving to the left neighbour |
| lout_last | output | LANES_L | Last flags of leaving leftbound lanes |
| lout_valid | output | LANES_L | Valid of leaving leftbound lanes |
| lout_ready | input | LANES_L | Ready from the left neighbour |

## Verification
The bench targets the moments where reservation state changes. In one test, three headers contend for the consumer in the same cycle. A wrong priority or a missed release would reorder or interleave their payloads. In another, a header arrives while both rightbound lanes are held. A node that dropped or overwrote it would lose words, and one that never freed a lane on the last flag would hang that stream. Two simultaneous leftbound streams show whether lanes are picked lowest-first and never shared. Further tests cover header removal at the destination and a stalled outgoing lane, where a design that ignored ready would repeat or skip words.

// File: rtl/ssn_pkg.sv
// Shared types for the streaming switch node.
// Assumes destinations and node indices fit in 32-bit unsigned values.
package ssn_pkg;

    typedef enum logic [1:0] {
        RT_LOCAL = 2'd0,
        RT_RIGHT = 2'd1,
        RT_LEFT  = 2'd2
    } route_e;

    // Picks the outgoing direction for a header destination.
    function automatic route_e route_of(input int unsigned dest, input int unsigned self);
        if (dest == self)     return RT_LOCAL;
        else if (dest > self) return RT_RIGHT;
        else                  return RT_LEFT;
    endfunction

endpackage

// File: rtl/ssn_alloc.sv
// Reservation table of the switch node.
// Keeps, per input, whether a stream is bound and which output it holds.
// Keeps, per output, whether it is busy and which input owns it.
// Output index 0 is the consumer, 1..LANES_R the rightbound lanes, and the
// leftbound lanes follow. Lower input index wins a contested output.
// Assumes the last flag of a stream is only seen on an accepted word.
module ssn_alloc
    import ssn_pkg::*;
#(
    parameter int NI      = 5,
    parameter int NO      = 5,
    parameter int LANES_R = 2,
    parameter int LANES_L = 2,
    parameter int ADDR_W  = 4,
    parameter int NODE_ID = 0,
    localparam int IW     = (NI > 1) ? $clog2(NI) : 1,
    localparam int OW     = (NO > 1) ? $clog2(NO) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NI-1:0]             in_valid,
    input  logic [NI-1:0]             in_last,
    input  logic [NI-1:0]             in_ready,
    input  logic [NI-1:0][ADDR_W-1:0] in_dest,
    output logic [NI-1:0]             bound_q,
    output logic [NI-1:0]             hdr_q,
    output logic [NI-1:0][OW-1:0]     tgt_q,
    output logic [NO-1:0]             busy_q,
    output logic [NO-1:0][IW-1:0]     owner_q
);

    logic [NO-1:0]         taken;
    logic [NI-1:0]         gnt;
    logic [NI-1:0][OW-1:0] gsel;
    logic [NI-1:0]         xfer;
    logic                  found;
    route_e                rt;

    // Accepted word on a bound input.
    assign xfer = bound_q & in_valid & in_ready;

    // Grants free outputs to waiting headers in fixed input order.
    always_comb begin
        taken = busy_q;
        gnt   = '0;
        gsel  = '0;
        found = 1'b0;
        rt    = RT_LOCAL;
        for (int i = 0; i < NI; i++) begin
            if (!bound_q[i] && in_valid[i]) begin
                rt    = route_of(32'(in_dest[i]), NODE_ID);
                found = 1'b0;
                if (rt == RT_LOCAL) begin
                    if (!taken[0]) begin
                        gnt[i]   = 1'b1;
                        gsel[i]  = '0;
                        taken[0] = 1'b1;
                    end
                end else if (rt == RT_RIGHT) begin
                    for (int k = 0; k < LANES_R; k++) begin
                        if (!found && !taken[1+k]) begin
                            found      = 1'b1;
                            gnt[i]     = 1'b1;
                            gsel[i]    = OW'(1 + k);
                            taken[1+k] = 1'b1;
                        end
                    end
                end else begin
                    for (int k = 0; k < LANES_L; k++) begin
                        if (!found && !taken[1+LANES_R+k]) begin
                            found              = 1'b1;
                            gnt[i]             = 1'b1;
                            gsel[i]            = OW'(1 + LANES_R + k);
                            taken[1+LANES_R+k] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Updates bindings: release on an accepted last word, then new grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound_q <= '0;
            hdr_q   <= '0;
            tgt_q   <= '0;
            busy_q  <= '0;
            owner_q <= '0;
        end else begin
            for (int i = 0; i < NI; i++) begin
                if (xfer[i]) hdr_q[i] <= 1'b0;
                if (xfer[i] && in_last[i]) begin
                    bound_q[i] <= 1'b0;
                    for (int o = 0; o < NO; o++)
                        if (tgt_q[i] == OW'(o)) busy_q[o] <= 1'b0;
                end
                if (gnt[i]) begin
                    bound_q[i] <= 1'b1;
                    hdr_q[i]   <= 1'b1;
                    tgt_q[i]   <= gsel[i];
                    for (int o = 0; o < NO; o++) begin
                        if (gsel[i] == OW'(o)) begin
                            busy_q[o]  <= 1'b1;
                            owner_q[o] <= IW'(i);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ssn_xbar.sv
// Data crossbar of the switch node.
// Steers each busy output from its owning input and returns ready to inputs.
// A header bound for the consumer (output 0) is swallowed: ready without valid.
// Assumes the reservation table never gives one output to two inputs.
module ssn_xbar #(
    parameter int NI     = 5,
    parameter int NO     = 5,
    parameter int DATA_W = 32,
    localparam int IW    = (NI > 1) ? $clog2(NI) : 1,
    localparam int OW    = (NO > 1) ? $clog2(NO) : 1
) (
    input  logic [NI-1:0][DATA_W-1:0] in_data,
    input  logic [NI-1:0]             in_last,
    input  logic [NI-1:0]             in_valid,
    output logic [NI-1:0]             in_ready,
    input  logic [NI-1:0]             bound_q,
    input  logic [NI-1:0]             hdr_q,
    input  logic [NI-1:0][OW-1:0]     tgt_q,
    input  logic [NO-1:0]             busy_q,
    input  logic [NO-1:0][IW-1:0]     owner_q,
    output logic [NO-1:0][DATA_W-1:0] out_data,
    output logic [NO-1:0]             out_last,
    output logic [NO-1:0]             out_valid,
    input  logic [NO-1:0]             out_ready
);

    // Forward path: each output takes the word of its owner.
    always_comb begin
        out_data  = '0;
        out_last  = '0;
        out_valid = '0;
        for (int o = 0; o < NO; o++) begin
            for (int i = 0; i < NI; i++) begin
                if (busy_q[o] && owner_q[o] == IW'(i)) begin
                    out_data[o]  = in_data[i];
                    out_last[o]  = in_last[i];
                    out_valid[o] = in_valid[i] && !(o == 0 && hdr_q[i]);
                end
            end
        end
    end

    // Return path: a bound input is ready when its output is.
    always_comb begin
        in_ready = '0;
        for (int i = 0; i < NI; i++) begin
            for (int o = 0; o < NO; o++) begin
                if (bound_q[i] && tgt_q[i] == OW'(o))
                    in_ready[i] = (o == 0 && hdr_q[i]) ? 1'b1 : out_ready[o];
            end
        end
    end

endmodule

// File: rtl/stream_switch_node.sv
// One node of a linear chain of circuit-switched stream switches.
// Inputs: rightbound lanes, leftbound lanes, local producer (in that priority).
// Outputs: local consumer, rightbound lanes, leftbound lanes.
// The header's low ADDR_W bits select the route; the last flag ends a stream.
// Assumes at least one lane in each direction and standard valid/ready senders.
module stream_switch_node #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int LANES_R = 2,
    parameter int LANES_L = 2,
    parameter int NODE_ID = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           prod_data,
    input  logic                        prod_last,
    input  logic                        prod_valid,
    output logic                        prod_ready,
    output logic [DATA_W-1:0]           cons_data,
    output logic                        cons_last,
    output logic                        cons_valid,
    input  logic                        cons_ready,
    input  logic [LANES_R*DATA_W-1:0]   rin_data,
    input  logic [LANES_R-1:0]          rin_last,
    input  logic [LANES_R-1:0]          rin_valid,
    output logic [LANES_R-1:0]          rin_ready,
    output logic [LANES_R*DATA_W-1:0]   rout_data,
    output logic [LANES_R-1:0]          rout_last,
    output logic [LANES_R-1:0]          rout_valid,
    input  logic [LANES_R-1:0]          rout_ready,
    input  logic [LANES_L*DATA_W-1:0]   lin_data,
    input  logic [LANES_L-1:0]          lin_last,
    input  logic [LANES_L-1:0]          lin_valid,
    output logic [LANES_L-1:0]          lin_ready,
    output logic [LANES_L*DATA_W-1:0]   lout_data,
    output logic [LANES_L-1:0]          lout_last,
    output logic [LANES_L-1:0]          lout_valid,
    input  logic [LANES_L-1:0]          lout_ready
);

    localparam int NI = LANES_R + LANES_L + 1;
    localparam int NO = LANES_R + LANES_L + 1;
    localparam int IW = (NI > 1) ? $clog2(NI) : 1;
    localparam int OW = (NO > 1) ? $clog2(NO) : 1;
    localparam int PI = NI - 1;

    logic [NI-1:0][DATA_W-1:0] i_data;
    logic [NI-1:0]             i_last, i_valid, i_ready;
    logic [NI-1:0][ADDR_W-1:0] i_dest;
    logic [NO-1:0][DATA_W-1:0] o_data;
    logic [NO-1:0]             o_last, o_valid, o_ready;
    logic [NI-1:0]             bound_q, hdr_q;
    logic [NI-1:0][OW-1:0]     tgt_q;
    logic [NO-1:0]             busy_q;
    logic [NO-1:0][IW-1:0]     owner_q;

    // Gathers rightbound lanes into input and output slots.
    for (genvar k = 0; k < LANES_R; k++) begin : g_rb
        assign i_data[k]    = rin_data[k*DATA_W +: DATA_W];
        assign i_last[k]    = rin_last[k];
        assign i_valid[k]   = rin_valid[k];
        assign rin_ready[k] = i_ready[k];
        assign rout_data[k*DATA_W +: DATA_W] = o_data[1+k];
        assign rout_last[k]  = o_last[1+k];
        assign rout_valid[k] = o_valid[1+k];
        assign o_ready[1+k]  = rout_ready[k];
    end

    // Gathers leftbound lanes into input and output slots.
    for (genvar k = 0; k < LANES_L; k++) begin : g_lb
        assign i_data[LANES_R+k]  = lin_data[k*DATA_W +: DATA_W];
        assign i_last[LANES_R+k]  = lin_last[k];
        assign i_valid[LANES_R+k] = lin_valid[k];
        assign lin_ready[k]       = i_ready[LANES_R+k];
        assign lout_data[k*DATA_W +: DATA_W] = o_data[1+LANES_R+k];
        assign lout_last[k]  = o_last[1+LANES_R+k];
        assign lout_valid[k] = o_valid[1+LANES_R+k];
        assign o_ready[1+LANES_R+k] = lout_ready[k];
    end

    // Local producer is the last input; local consumer is output 0.
    assign i_data[PI]  = prod_data;
    assign i_last[PI]  = prod_last;
    assign i_valid[PI] = prod_valid;
    assign prod_ready  = i_ready[PI];
    assign cons_data   = o_data[0];
    assign cons_last   = o_last[0];
    assign cons_valid  = o_valid[0];
    assign o_ready[0]  = cons_ready;

    // Destination field of every input word.
    for (genvar i = 0; i < NI; i++) begin : g_dest
        assign i_dest[i] = i_data[i][ADDR_W-1:0];
    end

    ssn_alloc #(
        .NI(NI), .NO(NO), .LANES_R(LANES_R), .LANES_L(LANES_L),
        .ADDR_W(ADDR_W), .NODE_ID(NODE_ID)
    ) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(i_valid), .in_last(i_last), .in_ready(i_ready), .in_dest(i_dest),
        .bound_q(bound_q), .hdr_q(hdr_q), .tgt_q(tgt_q),
        .busy_q(busy_q), .owner_q(owner_q)
    );

    ssn_xbar #(
        .NI(NI), .NO(NO), .DATA_W(DATA_W)
    ) u_xbar (
        .in_data(i_data), .in_last(i_last), .in_valid(i_valid), .in_ready(i_ready),
        .bound_q(bound_q), .hdr_q(hdr_q), .tgt_q(tgt_q),
        .busy_q(busy_q), .owner_q(owner_q),
        .out_data(o_data), .out_last(o_last), .out_valid(o_valid), .out_ready(o_ready)
    );

endmodule

// File: rtl/ssn_checker.sv
// Protocol checker for the switch node, attached by bind.
// Watches output handshakes and the reservation table.
module ssn_checker #(
    parameter int DATA_W  = 32,
    parameter int LANES_R = 2,
    parameter int LANES_L = 2,
    localparam int NO     = LANES_R + LANES_L + 1,
    localparam int IW     = (NO > 1) ? $clog2(NO) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cons_valid,
    input logic                      cons_ready,
    input logic                      cons_last,
    input logic [DATA_W-1:0]         cons_data,
    input logic [LANES_R*DATA_W-1:0] rout_data,
    input logic [LANES_R-1:0]        rout_valid,
    input logic [LANES_R-1:0]        rout_ready,
    input logic [LANES_R-1:0]        rout_last,
    input logic [LANES_L-1:0]        lout_valid,
    input logic [LANES_L-1:0]        lout_ready,
    input logic [LANES_L-1:0]        lout_last,
    input logic [NO-1:0]             busy_q,
    input logic [NO-1:0][IW-1:0]     owner_q
);

    logic shared;

    // Flags two busy outputs that name the same owner.
    always_comb begin
        shared = 1'b0;
        for (int a = 0; a < NO; a++)
            for (int b = a + 1; b < NO; b++)
                if (busy_q[a] && busy_q[b] && owner_q[a] == owner_q[b]) shared = 1'b1;
    end

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) !shared); // R6

    AST_CONS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_valid && !cons_ready) |=> (cons_valid && $stable(cons_data))); // R10

    AST_CONS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_valid && cons_ready && cons_last) |=> !cons_valid); // R5

    for (genvar k = 0; k < LANES_R; k++) begin : g_rchk
        AST_ROUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (rout_valid[k] && !rout_ready[k]) |=>
            (rout_valid[k] && $stable(rout_data[k*DATA_W +: DATA_W]))); // R10
        AST_ROUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (rout_valid[k] && rout_ready[k] && rout_last[k]) |=> !rout_valid[k]); // R5
    end

    for (genvar k = 0; k < LANES_L; k++) begin : g_lchk
        AST_LOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (lout_valid[k] && lout_ready[k] && lout_last[k]) |=> !lout_valid[k]); // R5
    end

endmodule

bind stream_switch_node ssn_checker #(
    .DATA_W(DATA_W), .LANES_R(LANES_R), .LANES_L(LANES_L)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cons_valid(cons_valid), .cons_ready(cons_ready), .cons_last(cons_last),
    .cons_data(cons_data),
    .rout_data(rout_data), .rout_valid(rout_valid), .rout_ready(rout_ready),
    .rout_last(rout_last),
    .lout_valid(lout_valid), .lout_ready(lout_ready), .lout_last(lout_last),
    .busy_q(busy_q), .owner_q(owner_q)
);

// File: tb/stream_switch_node_test.sv
// Directed bench: source queues feed the node, sink queues record its outputs.
// Sources: 0,1 rightbound in; 2,3 leftbound in; 4 producer.
// Sinks: 0 consumer; 1,2 rightbound out; 3,4 leftbound out.
`timescale 1ns/1ps
module stream_switch_node_test;

    localparam int NODE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [32:0] sq [5][$];
    logic [32:0] kq [5][$];
    logic [32:0] ex [$];
    logic [4:0]  src_v = '0, src_l = '0, acc = '0, snk_r = '1;
    logic [31:0] src_d [5];
    logic [4:0]  src_rdy, snk_v, snk_l;
    logic [31:0] snk_d [5];
    logic [63:0] rout_d, lout_d;
    logic [1:0]  rout_v, rout_l, lout_v, lout_l;
    logic [31:0] cons_d;
    logic        cons_v, cons_l;
    int nvec = 0, nbad = 0, nsamp = 0, t_src = -1, t_out = -1;
    bit done = 0;

    initial for (int s = 0; s < 5; s++) src_d[s] = '0;

    stream_switch_node #(.DATA_W(32), .ADDR_W(4), .LANES_R(2), .LANES_L(2), .NODE_ID(NODE)) uut (
        .clk(clk), .rst_n(rst_n),
        .prod_data(src_d[4]), .prod_last(src_l[4]), .prod_valid(src_v[4]), .prod_ready(src_rdy[4]),
        .cons_data(cons_d), .cons_last(cons_l), .cons_valid(cons_v), .cons_ready(snk_r[0]),
        .rin_data({src_d[1], src_d[0]}), .rin_last(src_l[1:0]), .rin_valid(src_v[1:0]),
        .rin_ready(src_rdy[1:0]),
        .rout_data(rout_d), .rout_last(rout_l), .rout_valid(rout_v), .rout_ready(snk_r[2:1]),
        .lin_data({src_d[3], src_d[2]}), .lin_last(src_l[3:2]), .lin_valid(src_v[3:2]),
        .lin_ready(src_rdy[3:2]),
        .lout_data(lout_d), .lout_last(lout_l), .lout_valid(lout_v), .lout_ready(snk_r[4:3])
    );

    assign snk_v = {lout_v, rout_v, cons_v};
    assign snk_l = {lout_l, rout_l, cons_l};
    assign snk_d[0] = cons_d;
    assign snk_d[1] = rout_d[31:0];
    assign snk_d[2] = rout_d[63:32];
    assign snk_d[3] = lout_d[31:0];
    assign snk_d[4] = lout_d[63:32];

    // Drives sources at the falling edge, samples handshakes just before the rising edge.
    always begin
        @(negedge clk);
        for (int s = 0; s < 5; s++) begin
            if (acc[s]) void'(sq[s].pop_front());
            if (sq[s].size() > 0) begin
                {src_l[s], src_d[s]} = sq[s][0];
                src_v[s] = 1'b1;
            end else begin
                src_v[s] = 1'b0;
                src_l[s] = 1'b0;
            end
        end
        #2;
        nsamp++;
        for (int s = 0; s < 5; s++) begin
            acc[s] = src_v[s] && src_rdy[s];
            if (snk_v[s] && snk_r[s]) kq[s].push_back({snk_l[s], snk_d[s]});
        end
        if (src_v[4] && t_src < 0) t_src = nsamp;
        if (rout_v[0] && t_out < 0) t_out = nsamp;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int s, input logic last, input logic [31:0] d);
        sq[s].push_back({last, d});
    endtask

    // Compares a sink's recorded words with ex.
    task automatic check_sink(input int s, input string req);
        chk(kq[s].size() == ex.size(), req, kq[s].size(), ex.size());
        for (int i = 0; i < ex.size() && i < kq[s].size(); i++)
            chk(kq[s][i] == ex[i], req, kq[s][i], ex[i]);
    endtask

    task automatic clear_sinks();
        for (int s = 0; s < 5; s++) kq[s].delete();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #1;
        chk(snk_v == '0, "R1 outputs idle in reset", snk_v, 0);
        chk(src_rdy == '0, "R1 inputs not ready in reset", src_rdy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(snk_v == '0 && src_rdy == '0, "R1 idle after reset", {snk_v, src_rdy}, 0);
    endtask

    task automatic t_local();
        clear_sinks();
        push(0, 0, 32'hA0000002); push(0, 0, 32'h11); push(0, 0, 32'h12); push(0, 1, 32'h13);
        repeat (12) @(negedge clk);
        #1;
        ex = '{{1'b0, 32'h11}, {1'b0, 32'h12}, {1'b1, 32'h13}};
        check_sink(0, "R2 local delivery, header dropped");
    endtask

    task automatic t_right_latency();
        clear_sinks();
        t_src = -1; t_out = -1;
        push(4, 0, 32'h5); push(4, 0, 32'h61); push(4, 1, 32'h62);
        repeat (12) @(negedge clk);
        #1;
        ex = '{{1'b0, 32'h5}, {1'b0, 32'h61}, {1'b1, 32'h62}};
        check_sink(1, "R3 rightbound stream with header");
        chk(kq[2].size() == 0, "R6 lane 1 unused", kq[2].size(), 0);
        chk(t_out - t_src == 1, "R9 setup latency", t_out - t_src, 1);
    endtask

    task automatic t_priority();
        clear_sinks();
        push(0, 0, 32'h2); push(0, 0, 32'h11); push(0, 1, 32'h12);
        push(2, 0, 32'h2); push(2, 0, 32'h21); push(2, 1, 32'h22);
        push(4, 0, 32'h2); push(4, 1, 32'h31);
        repeat (20) @(negedge clk);
        #1;
        ex = '{{1'b0, 32'h11}, {1'b1, 32'h12}, {1'b0, 32'h21}, {1'b1, 32'h22}, {1'b1, 32'h31}};
        check_sink(0, "R8 fixed priority order at consumer");
    endtask

    task automatic t_left_pair();
        clear_sinks();
        push(2, 0, 32'h0); push(2, 0, 32'h41); push(2, 1, 32'h42);
        push(4, 0, 32'h1); push(4, 0, 32'h51); push(4, 1, 32'h52);
        repeat (12) @(negedge clk);
        #1;
        ex = '{{1'b0, 32'h0}, {1'b0, 32'h41}, {1'b1, 32'h42}};
        check_sink(3, "R4 R6 leftbound lane 0");
        ex = '{{1'b0, 32'h1}, {1'b0, 32'h51}, {1'b1, 32'h52}};
        check_sink(4, "R4 R6 leftbound lane 1");
    endtask

    task automatic t_blocked();
        clear_sinks();
        push(0, 0, 32'h7); push(0, 0, 32'h81);
        push(1, 0, 32'h6); push(1, 0, 32'h91);
        repeat (5) @(negedge clk);
        push(4, 0, 32'h5); push(4, 0, 32'h101); push(4, 1, 32'h102);
        repeat (8) @(negedge clk);
        #1;
        chk(sq[4].size() == 3, "R7 header held while lanes busy", sq[4].size(), 3);
        chk(src_rdy[4] == 1'b0, "R7 producer backpressured", src_rdy[4], 0);
        chk(kq[1].size() == 2, "R7 no stray words on lane 0", kq[1].size(), 2);
        push(0, 1, 32'h83);
        repeat (12) @(negedge clk);
        #1;
        ex = '{{1'b0, 32'h7}, {1'b0, 32'h81}, {1'b1, 32'h83},
               {1'b0, 32'h5}, {1'b0, 32'h101}, {1'b1, 32'h102}};
        check_sink(1, "R5 R7 lane reused after release");
        push(1, 1, 32'h93);
        repeat (6) @(negedge clk);
        #1;
        ex = '{{1'b0, 32'h6}, {1'b0, 32'h91}, {1'b1, 32'h93}};
        check_sink(2, "R6 second lane stream intact");
    endtask

    task automatic t_stall();
        logic [31:0] d0;
        clear_sinks();
        snk_r[1] = 1'b0;
        push(4, 0, 32'h4); push(4, 0, 32'h111); push(4, 1, 32'h112);
        repeat (4) @(negedge clk);
        #1;
        d0 = snk_d[1];
        chk(rout_v[0] && d0 == 32'h4, "R10 stalled header presented", d0, 32'h4);
        @(negedge clk);
        #1;
        chk(rout_v[0] && snk_d[1] == d0, "R10 data stable under stall", snk_d[1], d0);
        chk(kq[1].size() == 0, "R10 nothing moved without ready", kq[1].size(), 0);
        snk_r[1] = 1'b1;
        repeat (8) @(negedge clk);
        #1;
        ex = '{{1'b0, 32'h4}, {1'b0, 32'h111}, {1'b1, 32'h112}};
        check_sink(1, "R10 stream complete after stall");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_local();
        t_right_latency();
        t_priority();
        t_left_pair();
        t_blocked();
        t_stall();
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200000;
        nvec++;
        nbad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

endmodule